// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single bus-cycle requests from a controller front end into the pin waveforms of a raw NAND flash interface. Each request is one command write, one address write, one data write or one data read. For each request the block asserts the chip enable, holds the latch-enable lines and the data bus, pulses the write or read strobe, and reports completion with a one-clock done pulse. For a read it also returns the captured bus value at that moment.

All timing comes from clock-count inputs that a configuration layer sets up: strobe low and high widths, chip-enable setup, the read sample point, and the minimum gaps that must separate certain kinds of cycles. The front end issues a request whenever the block is ready. The block then stretches the cycle so that every applicable gap and the minimum strobe period are met. Both 8-bit and 16-bit devices are supported. In 16-bit mode the two bytes of a bus word map to bits 7:0 and 23:16 of the 32-bit host word. The configuration inputs must stay stable while a cycle is in progress.

Top module: `nand_bus_timer`

## Requirements
- R1: After reset, nand_ce_n=1, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_dq_oe=0, done=0, req_ready=1 and rd_word=0. The first cycle after reset waits for no inter-cycle gap.
- R2: req_kind encodes 0 command write, 1 address write, 2 data write, 3 data read. A command cycle holds nand_cle=1 and an address cycle holds nand_ale=1 for every clock in which nand_ce_n is low. Data cycles assert neither line.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the next clock, nand_ce_n is low for P+L+H clocks: a setup part of P clocks, the strobe (nand_we_n for kinds 0-2, nand_re_n for kind 3) low for L clocks, then high for H clocks. Next, nand_ce_n returns high and done is 1 for exactly that one clock. req_ready is 1 only while nand_ce_n is high.
- R4: H is the larger of the effective high count and CLK_RATIO (default 4) minus L, so that L+H is never below CLK_RATIO.
- R5: Every count input whose value is zero acts as one clock.
- R6: During a write cycle, nand_dq_oe=1 while nand_ce_n is low. nand_dq_out is {8'h00, wdata[7:0]} in 8-bit mode and {wdata[23:16], wdata[7:0]} in 16-bit mode. During a read cycle nand_dq_oe=0.
- R7: A read captures nand_dq_in at the end of the A-th strobe clock, where the first strobe-low clock counts as 1 and A is the effective access count. A is clamped to L+H.
- R8: A captured 8-bit read returns {24'h0, dq[7:0]}. A captured 16-bit read returns {8'h0, dq[15:8], 8'h0, dq[7:0]}.
- R9: P is the effective setup count plus a gap G. G is the write-to-read count when a read follows a command, address or data write. It is the read-to-write count when a write kind follows a read. It is the read-to-read count when a read follows a read. Otherwise G is 0.
- R10: When a data cycle follows an address cycle, G is at least the address-to-data count. With cfg_a2d_narrow=1, that count saturates at 63.
- R11: The setup count adds its effective value in clocks before the first strobe edge, even when no gap applies.
- R12: rd_word is valid in the clock where done is 1 after a read. It keeps its value through later write cycles until the next read captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 2 | Cycle kind (see R2) |
| req_wdata | input | 32 | Command, address or write data word |
| req_ready | output | 1 | Block idle, request can be taken |
| done | output | 1 | One-clock completion pulse |
| rd_word | output | 32 | Captured read data, packed per R8 |
| cfg_wide16 | input | 1 | 1 selects a 16-bit device |
| cfg_lo_cnt | input | LO_W | Strobe low width in clocks |
| cfg_hi_cnt | input | HI_W | Strobe high width in clocks |
| cfg_acc_cnt | input | ACC_W | Read sample point after the strobe falls |
| cfg_setup_cnt | input | SETUP_W | Chip-enable setup clocks |
| cfg_w2r_cnt | input | GAP_W | Write-to-read gap |
| cfg_r2w_cnt | input | GAP_W | Read-to-write gap |
| cfg_r2r_cnt | input | GAP_W | Read-to-read gap |
| cfg_a2d_cnt | input | A2D_W | Address-to-data gap |
| cfg_a2d_narrow | input | 1 | Saturate the address-to-data gap at 63 |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus driven value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus sampled value |

## Verification
The embedded assertions watch invariants on every clock. Both strobes are never low together, and a strobe is low only inside chip enable. The two latch enables never overlap. Done is a single-clock pulse that follows the strobe-high phase, and a finished read always has a capture behind it. A write kind following a read, or a read following a write, always gets a non-zero gap.

Only the bench's scenarios can show the exact clock counts of each phase:
- the ratio stretch and zero-as-one handling
- which gap is chosen for each pair of cycle kinds
- the address-to-data maximum and the 63 clamp
- the precise sample edge and its clamp
- the byte packing in both widths

The bench compares every pin against a queue-based reference on every clock.

// File: rtl/nbt_pkg.sv
// Package: shared types for the NAND bus cycle timing generator.
// Assumes: cycle kind codes are fixed by the front-end interface (R2).
package nbt_pkg;
    typedef enum logic [1:0] {
        K_CMD   = 2'd0,
        K_ADDR  = 2'd1,
        K_WDATA = 2'd2,
        K_RDATA = 2'd3
    } nbt_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } nbt_phase_e;
endpackage

// File: rtl/nbt_gap_sel.sv
// Module: nbt_gap_sel
// Remembers the kind of the last accepted cycle and selects the gap the
// next cycle must wait. Assumes accept pulses only when the sequencer is idle.
module nbt_gap_sel
    import nbt_pkg::*;
#(
    parameter int GAP_W      = 6,
    parameter int A2D_W      = 7,
    parameter int CNT_W      = 9,
    parameter int NARROW_MAX = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  nbt_kind_e        kind,
    input  logic [GAP_W-1:0] w2r_cnt,
    input  logic [GAP_W-1:0] r2w_cnt,
    input  logic [GAP_W-1:0] r2r_cnt,
    input  logic [A2D_W-1:0] a2d_cnt,
    input  logic             a2d_narrow,
    output logic [CNT_W-1:0] gap
);
    logic             has_prev;
    nbt_kind_e        prev_kind;
    logic [A2D_W-1:0] a2d_sat;
    logic [CNT_W-1:0] g_w2r, g_r2w, g_r2r, g_a2d;
    logic             cur_rd, prev_rd, to_data;

    // Clamp address-to-data count on narrow-field revisions.
    assign a2d_sat = (a2d_narrow && (a2d_cnt > A2D_W'(NARROW_MAX)))
                     ? A2D_W'(NARROW_MAX) : a2d_cnt;

    // Zero-count-as-one conversion of each gap.
    assign g_w2r = (w2r_cnt == '0) ? CNT_W'(1) : CNT_W'(w2r_cnt);
    assign g_r2w = (r2w_cnt == '0) ? CNT_W'(1) : CNT_W'(r2w_cnt);
    assign g_r2r = (r2r_cnt == '0) ? CNT_W'(1) : CNT_W'(r2r_cnt);
    assign g_a2d = (a2d_sat == '0) ? CNT_W'(1) : CNT_W'(a2d_sat);

    assign cur_rd  = (kind == K_RDATA);
    assign prev_rd = (prev_kind == K_RDATA);
    assign to_data = (kind == K_WDATA) || (kind == K_RDATA);

    // Pick the transition gap, then raise it to the address-to-data count.
    always_comb begin
        gap = '0;
        if (has_prev) begin
            if (prev_rd && cur_rd)  gap = g_r2r;
            else if (prev_rd)       gap = g_r2w;
            else if (cur_rd)        gap = g_w2r;
            if ((prev_kind == K_ADDR) && to_data && (g_a2d > gap))
                gap = g_a2d;
        end
    end

    // Record the kind of each accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_prev  <= 1'b0;
            prev_kind <= K_CMD;
        end else if (accept) begin
            has_prev  <= 1'b1;
            prev_kind <= kind;
        end
    end

    p_dir_change_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && has_prev && (prev_rd != cur_rd)) |-> (gap != '0));
endmodule

// File: rtl/nbt_seq.sv
// Module: nbt_seq
// Phase sequencer: setup/gap, strobe low, strobe high, then a done pulse.
// Assumes lengths are at least one and stay stable during a cycle.
module nbt_seq
    import nbt_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int EN_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CNT_W-1:0] pre_len,
    input  logic [EN_W-1:0]  lo_len,
    input  logic [EN_W-1:0]  hi_len,
    output nbt_phase_e      phase,
    output logic [EN_W-1:0] pos,
    output logic            fin
);
    localparam int CW = (CNT_W > EN_W) ? CNT_W : EN_W;
    logic [CW-1:0] cnt;

    // Advance through the phases, counting each one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            pos   <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_PRE;
                    cnt   <= CW'(pre_len) - CW'(1);
                end
                PH_PRE: if (cnt == '0) begin
                    phase <= PH_LOW;
                    cnt   <= CW'(lo_len) - CW'(1);
                    pos   <= EN_W'(1);
                end else begin
                    cnt <= cnt - CW'(1);
                end
                PH_LOW: begin
                    pos <= pos + EN_W'(1);
                    if (cnt == '0) begin
                        phase <= PH_HIGH;
                        cnt   <= CW'(hi_len) - CW'(1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    pos <= pos + EN_W'(1);
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        fin   <= 1'b1;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    p_fin_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ($past(phase) == PH_HIGH) && (phase == PH_IDLE));
endmodule

// File: rtl/nbt_rd_capture.sv
// Module: nbt_rd_capture
// Samples the bus on the read sample edge and packs it into the host word.
// Assumes the bus is 16 bits and the host word 32 bits.
module nbt_rd_capture #(
    parameter int DQ_W   = 16,
    parameter int HOST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              wide16,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [HOST_W-1:0] rd_word,
    output logic              took
);
    localparam int BYTE = DQ_W / 2;

    // Capture and pack on the sample edge; track whether a capture happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
            took    <= 1'b0;
        end else if (sample) begin
            took <= 1'b1;
            if (wide16)
                rd_word <= HOST_W'({dq_in[DQ_W-1:BYTE], {BYTE{1'b0}}, dq_in[BYTE-1:0]});
            else
                rd_word <= HOST_W'(dq_in[BYTE-1:0]);
        end else if (clear) begin
            took <= 1'b0;
        end
    end
endmodule

// File: rtl/nand_bus_timer.sv
// Module: nand_bus_timer (top)
// Generates CE/CLE/ALE/WE/RE/data waveforms for single NAND bus cycles with
// programmable clock counts. Assumes configuration is static during a cycle.
module nand_bus_timer
    import nbt_pkg::*;
#(
    parameter int LO_W       = 4,
    parameter int HI_W       = 4,
    parameter int ACC_W      = 4,
    parameter int SETUP_W    = 5,
    parameter int GAP_W      = 6,
    parameter int A2D_W      = 7,
    parameter int NARROW_MAX = 63,
    parameter int CLK_RATIO  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [31:0]        req_wdata,
    output logic               req_ready,
    output logic               done,
    output logic [31:0]        rd_word,
    input  logic               cfg_wide16,
    input  logic [LO_W-1:0]    cfg_lo_cnt,
    input  logic [HI_W-1:0]    cfg_hi_cnt,
    input  logic [ACC_W-1:0]   cfg_acc_cnt,
    input  logic [SETUP_W-1:0] cfg_setup_cnt,
    input  logic [GAP_W-1:0]   cfg_w2r_cnt,
    input  logic [GAP_W-1:0]   cfg_r2w_cnt,
    input  logic [GAP_W-1:0]   cfg_r2r_cnt,
    input  logic [A2D_W-1:0]   cfg_a2d_cnt,
    input  logic               cfg_a2d_narrow,
    output logic               nand_ce_n,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [15:0]        nand_dq_out,
    output logic               nand_dq_oe,
    input  logic [15:0]        nand_dq_in
);
    localparam int MAX_EN = (LO_W > HI_W) ? LO_W : HI_W;
    localparam int EN_W   = ((MAX_EN > ACC_W) ? MAX_EN : ACC_W) + 2;
    localparam int MAX_G  = (A2D_W > GAP_W) ? A2D_W : GAP_W;
    localparam int CNT_W  = ((MAX_G > SETUP_W) ? MAX_G : SETUP_W) + 2;

    nbt_phase_e       phase;
    nbt_kind_e        kind_q;
    logic [7:0]       wlo_q, whi_q;
    logic             accept, fin, took, is_rd;
    logic [EN_W-1:0]  pos, lo_eff, hi_eff, hi_fill, hi_len, en_total, acc_eff, acc_pt;
    logic [CNT_W-1:0] gap, setup_eff, pre_len;
    logic             unused_host_bytes;

    assign unused_host_bytes = ^{req_wdata[31:24], req_wdata[15:8]};
    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign is_rd     = (kind_q == K_RDATA);

    // Effective counts: zero acts as one, high width stretched to the ratio.
    assign lo_eff    = (cfg_lo_cnt == '0) ? EN_W'(1) : EN_W'(cfg_lo_cnt);
    assign hi_eff    = (cfg_hi_cnt == '0) ? EN_W'(1) : EN_W'(cfg_hi_cnt);
    assign acc_eff   = (cfg_acc_cnt == '0) ? EN_W'(1) : EN_W'(cfg_acc_cnt);
    assign setup_eff = (cfg_setup_cnt == '0) ? CNT_W'(1) : CNT_W'(cfg_setup_cnt);
    assign hi_fill   = (lo_eff >= EN_W'(CLK_RATIO)) ? '0 : EN_W'(CLK_RATIO) - lo_eff;
    assign hi_len    = (hi_fill > hi_eff) ? hi_fill : hi_eff;
    assign en_total  = lo_eff + hi_len;
    assign acc_pt    = (acc_eff > en_total) ? en_total : acc_eff;
    assign pre_len   = setup_eff + gap;

    // Latch the request kind and the data bytes on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_CMD;
            wlo_q  <= '0;
            whi_q  <= '0;
        end else if (accept) begin
            kind_q <= nbt_kind_e'(req_kind);
            wlo_q  <= req_wdata[7:0];
            whi_q  <= req_wdata[23:16];
        end
    end

    nbt_gap_sel #(.GAP_W(GAP_W), .A2D_W(A2D_W), .CNT_W(CNT_W), .NARROW_MAX(NARROW_MAX)) u_gap (
        .clk(clk), .rst_n(rst_n), .accept(accept), .kind(nbt_kind_e'(req_kind)),
        .w2r_cnt(cfg_w2r_cnt), .r2w_cnt(cfg_r2w_cnt), .r2r_cnt(cfg_r2r_cnt),
        .a2d_cnt(cfg_a2d_cnt), .a2d_narrow(cfg_a2d_narrow), .gap(gap)
    );

    nbt_seq #(.CNT_W(CNT_W), .EN_W(EN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .pre_len(pre_len),
        .lo_len(lo_eff), .hi_len(hi_len), .phase(phase), .pos(pos), .fin(fin)
    );

    nbt_rd_capture #(.DQ_W(16), .HOST_W(32)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .sample(is_rd && ((phase == PH_LOW) || (phase == PH_HIGH)) && (pos == acc_pt)),
        .wide16(cfg_wide16), .dq_in(nand_dq_in), .rd_word(rd_word), .took(took)
    );

    // Decode pin levels from the phase and the latched kind.
    always_comb begin
        nand_ce_n   = (phase == PH_IDLE);
        nand_cle    = !nand_ce_n && (kind_q == K_CMD);
        nand_ale    = !nand_ce_n && (kind_q == K_ADDR);
        nand_we_n   = !((phase == PH_LOW) && !is_rd);
        nand_re_n   = !((phase == PH_LOW) && is_rd);
        nand_dq_oe  = !nand_ce_n && !is_rd;
        nand_dq_out = cfg_wide16 ? {whi_q, wlo_q} : {8'h00, wlo_q};
    end

    assign done = fin;

    p_enable_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    p_enable_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_read_has_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_rd) |-> took);
endmodule

// File: tb/nand_bus_timer_tb.sv
module nand_bus_timer_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, done;
    logic [31:0] rd_word;
    logic        cfg_wide16 = 1'b0, cfg_a2d_narrow = 1'b0;
    logic [3:0]  cfg_lo_cnt = 4'd2, cfg_hi_cnt = 4'd3, cfg_acc_cnt = 4'd3;
    logic [4:0]  cfg_setup_cnt = 5'd1;
    logic [5:0]  cfg_w2r_cnt = 6'd2, cfg_r2w_cnt = 6'd3, cfg_r2r_cnt = 6'd4;
    logic [6:0]  cfg_a2d_cnt = 7'd5;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out, nand_dq_in = '0;

    nand_bus_timer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rd_word(rd_word),
        .cfg_wide16(cfg_wide16), .cfg_lo_cnt(cfg_lo_cnt), .cfg_hi_cnt(cfg_hi_cnt),
        .cfg_acc_cnt(cfg_acc_cnt), .cfg_setup_cnt(cfg_setup_cnt),
        .cfg_w2r_cnt(cfg_w2r_cnt), .cfg_r2w_cnt(cfg_r2w_cnt), .cfg_r2r_cnt(cfg_r2r_cnt),
        .cfg_a2d_cnt(cfg_a2d_cnt), .cfg_a2d_narrow(cfg_a2d_narrow),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
    );

    typedef struct packed {
        logic ce_n, cle, ale, we_n, re_n, oe, dn, rdy, smp, isrd;
        logic [15:0] dq;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0, n_fail = 0, tick = 0, cyc = 0, prev_kind = -1;
    string       cur_req = "R1";
    bit          chk_en = 0;
    logic [31:0] exp_rd = '0, pend_rd = '0;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Reference comparison of every pin on every falling edge; also drives the bus.
    always @(negedge clk) begin
        if (chk_en) begin
            exp_t e;
            logic [15:0] dqv;
            tick++;
            dqv = {tick[7:0] ^ 8'h5A, tick[7:0] + 8'h30};
            if (q.size() != 0) e = q.pop_front();
            else e = '{ce_n:1, cle:0, ale:0, we_n:1, re_n:1, oe:0, dn:0, rdy:1, smp:0, isrd:0, dq:'0};
            check(cur_req, "pins{ce,cle,ale,we,re,oe,done,rdy}",
                  64'({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, done, req_ready}),
                  64'({e.ce_n, e.cle, e.ale, e.we_n, e.re_n, e.oe, e.dn, e.rdy}));
            if (e.oe) check(cur_req, "dq_out", 64'(nand_dq_out), 64'(e.dq));
            if (e.smp)
                pend_rd = cfg_wide16 ? {8'h00, dqv[15:8], 8'h00, dqv[7:0]} : {24'h0, dqv[7:0]};
            if (e.dn) begin
                if (e.isrd) exp_rd = pend_rd;
                check(e.isrd ? cur_req : "R12", "rd_word", 64'(rd_word), 64'(exp_rd));
            end
            nand_dq_in = dqv;
        end
    end

    task automatic wait_idle();
        do begin @(posedge clk); #2; end while (q.size() != 0);
    endtask

    // Issue one cycle and push its expected per-clock pin values.
    task automatic issue(input int kind, input logic [31:0] w);
        int g, pre, lo, hi, tot, acc, a2d;
        exp_t e;
        wait_idle();
        req_valid = 1'b1; req_kind = kind[1:0]; req_wdata = w;
        @(posedge clk);
        g = 0;
        a2d = (cfg_a2d_narrow && cfg_a2d_cnt > 63) ? 63 : int'(cfg_a2d_cnt);
        if (prev_kind >= 0) begin
            if (prev_kind == 3 && kind == 3) g = eff(cfg_r2r_cnt);
            else if (prev_kind == 3) g = eff(cfg_r2w_cnt);
            else if (kind == 3) g = eff(cfg_w2r_cnt);
            if (prev_kind == 1 && kind >= 2 && eff(a2d) > g) g = eff(a2d);
        end
        pre = eff(cfg_setup_cnt) + g;
        lo  = eff(cfg_lo_cnt);
        hi  = eff(cfg_hi_cnt);
        if (lo + hi < 4) hi = 4 - lo;
        tot = lo + hi;
        acc = eff(cfg_acc_cnt);
        if (acc > tot) acc = tot;
        e = '{ce_n:0, cle:(kind == 0), ale:(kind == 1), we_n:1, re_n:1, oe:(kind != 3),
              dn:0, rdy:0, smp:0, isrd:0,
              dq:(cfg_wide16 ? {w[23:16], w[7:0]} : {8'h00, w[7:0]})};
        for (int i = 0; i < pre; i++) q.push_back(e);
        for (int i = 1; i <= tot; i++) begin
            exp_t s = e;
            if (i <= lo) begin
                if (kind == 3) s.re_n = 0; else s.we_n = 0;
            end
            s.smp = (kind == 3) && (i == acc);
            q.push_back(s);
        end
        e = '{ce_n:1, cle:0, ale:0, we_n:1, re_n:1, oe:0, dn:1, rdy:1, smp:0, isrd:(kind == 3), dq:'0};
        q.push_back(e);
        prev_kind = kind;
        #1 req_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0d exp<=50000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_en = 1;
        // R1: reset values and idle pins
        #3 check("R1", "rd_word reset", 64'(rd_word), 64'h0);
        repeat (3) @(posedge clk);
        // R2/R11: command, no gap before first cycle (R1), then address
        cur_req = "R2"; issue(0, 32'h70);
        cur_req = "R2"; issue(1, 32'h12);
        // R10: read after address takes max(w2r=2, a2d=5); R7 sample at 3
        cur_req = "R10"; issue(3, 0);
        cur_req = "R9";  issue(3, 0);
        cur_req = "R6";  issue(2, 32'hAB);
        cur_req = "R9";  issue(3, 0);
        cur_req = "R3";  issue(2, 32'h5C);
        // R4: ratio stretch with short widths
        wait_idle(); cfg_lo_cnt = 4'd1; cfg_hi_cnt = 4'd1;
        cur_req = "R4"; issue(0, 32'hFF);
        // R5: zero counts act as one
        wait_idle(); cfg_lo_cnt = 0; cfg_hi_cnt = 0; cfg_setup_cnt = 0; cfg_acc_cnt = 0; cfg_w2r_cnt = 0;
        cur_req = "R5"; issue(3, 0);
        cur_req = "R5"; issue(0, 32'h90);
        cur_req = "R5"; issue(3, 0);
        // R11: long setup
        wait_idle(); cfg_lo_cnt = 4'd2; cfg_hi_cnt = 4'd3; cfg_setup_cnt = 5'd7; cfg_acc_cnt = 4'd3;
        cur_req = "R11"; issue(0, 32'h60);
        // R7: access count clamps to the strobe period
        wait_idle(); cfg_setup_cnt = 5'd1; cfg_acc_cnt = 4'd15;
        cur_req = "R7"; issue(3, 0);
        wait_idle(); cfg_acc_cnt = 4'd1;
        cur_req = "R7"; issue(3, 0);
        // R6/R8: 16-bit mode write and read packing
        wait_idle(); cfg_wide16 = 1'b1; cfg_acc_cnt = 4'd2;
        cur_req = "R6"; issue(2, 32'h00CD00EF);
        cur_req = "R8"; issue(3, 0);
        cur_req = "R12"; issue(2, 32'h00112233);
        // R10: narrow clamp to 63 versus full 100
        wait_idle(); cfg_wide16 = 1'b0; cfg_a2d_cnt = 7'd100; cfg_a2d_narrow = 1'b1;
        cur_req = "R10"; issue(1, 32'h01);
        cur_req = "R10"; issue(2, 32'h44);
        wait_idle(); cfg_a2d_narrow = 1'b0;
        cur_req = "R10"; issue(1, 32'h02);
        cur_req = "R10"; issue(3, 0);
        wait_idle();
        cur_req = "R1";
        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule